// File: doc/BRIEF.md
# Sync Source Selector and Polarity Normalizer

This block sits at the front of a display timing path. It picks one of two horizontal sync sources and one of two vertical sync sources, using two select bits held in a control register. It then works out whether each chosen signal is active-high or active-low. Any signal found to be active-low is inverted, so every later stage always receives active-high pulses. All four sync inputs are treated as asynchronous and pass through a synchronizer chain before any other logic sees them.

Polarity is found from the duty of the signal. Between two rising edges of the synchronized source, the block counts the clocks spent high and the clocks spent low. A source that is high for longer than it is low is taken to be active-low. Each path raises a valid flag once it has made a set number of period decisions since reset or since the last change of a select bit. The horizontal path needs a few lines to settle. The vertical path needs at least five frames, and elaboration rejects any smaller setting.

Top module: `sync_polarity_norm`

## Requirements
- R1: With `h_sel` = 0 the horizontal path uses `hsync_in`; with `h_sel` = 1 it uses `sog_in`. The source that is not selected has no effect on `h_out`, `h_pol_neg` or `h_valid`.
- R2: With `v_sel` = 0 the vertical path uses `vsync_in`; with `v_sel` = 1 it uses `vsep_in`. The source that is not selected has no effect on `v_out`, `v_pol_neg` or `v_valid`.
- R3: Each input passes through `SYNC_STAGES` (default 2) flip-flops. A change on the selected input reaches the normalized output exactly `SYNC_STAGES` clocks later.
- R4: A period runs from one rising edge of the synchronized selected signal to the next. The high count includes the cycle of the rising edge. At the end of each period the polarity flag (1 = active-low) is set to 1 when the high count exceeds the low count, and to 0 otherwise. Equal counts give 0.
- R5: The normalized output equals the synchronized selected signal XOR the polarity flag of that path.
- R6: Since the last restart, the first rising edge on the horizontal path only arms the path, and each later rising edge is one decision. `h_valid` rises at decision number `H_SETTLE` (the edge numbered `H_SETTLE`+1) and stays high until the next restart.
- R7: `v_valid` follows the same rule with `V_SETTLE` decisions. Elaboration fails if `V_SETTLE` is less than 5.
- R8: A change of either `h_sel` or `v_sel` clears both valid flags and both polarity flags on the next clock, and restarts both settling counts.
- R9: While `rst_n` is low, all outputs are 0.
- R10: A polarity flag changes only at a period decision or a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_sel | input | 1 | Horizontal source select: 0 = hsync_in, 1 = sog_in |
| v_sel | input | 1 | Vertical source select: 0 = vsync_in, 1 = vsep_in |
| hsync_in | input | 1 | Separate horizontal sync, asynchronous |
| sog_in | input | 1 | Sliced sync taken from the green channel, asynchronous |
| vsync_in | input | 1 | Separate vertical sync, asynchronous |
| vsep_in | input | 1 | Vertical sync separated from a composite signal, asynchronous |
| h_out | output | 1 | Horizontal sync, always active high |
| v_out | output | 1 | Vertical sync, always active high |
| h_pol_neg | output | 1 | Horizontal source detected as active low |
| v_pol_neg | output | 1 | Vertical source detected as active low |
| h_valid | output | 1 | Horizontal polarity decision has settled |
| v_valid | output | 1 | Vertical polarity decision has settled |

## Verification
The bench sweeps every high time of two period lengths, across all four select combinations. The source that is not selected carries the complement of the selected waveform, so a swapped multiplexer leg reports the opposite polarity. A sweep that passes through equal duty catches a design that breaks ties toward inversion. Each valid flag is checked on both sides of its settling point, which catches a design that counts the arming edge as a decision or uses the wrong threshold. Every run is preceded by a single-bit select flip to show that either bit clears both paths, and the outputs are compared against the input delayed by exactly two clocks, so extra or missing synchronizer stages show up.

// File: rtl/spn_pkg.sv
package spn_pkg;
   typedef struct packed {
      logic neg;    // source is active low
      logic valid;  // decision has settled
   } pol_stat_t;
endpackage

// File: rtl/spn_sync_chain.sv
module spn_sync_chain #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spn_sync_chain: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spn_sync_chain: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spn_pol_detect.sv
module spn_pol_detect
   import spn_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int SETTLE = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart,
   input  logic      sig,
   output pol_stat_t stat
);
   localparam int SET_W = $clog2(SETTLE + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [SET_W-1:0] SET_LIM = SET_W'(SETTLE);

   if (SETTLE < 1) begin : g_bad_settle
      $error("spn_pol_detect: SETTLE must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("spn_pol_detect: CNT_W must be at least 2");
   end

   logic             sig_d;
   logic             armed;
   logic [CNT_W-1:0] hi_cnt;
   logic [CNT_W-1:0] lo_cnt;
   logic [SET_W-1:0] dec_cnt;
   logic             rise;

   assign rise = sig & ~sig_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_d   <= 1'b0;
         armed   <= 1'b0;
         hi_cnt  <= '0;
         lo_cnt  <= '0;
         dec_cnt <= '0;
         stat    <= '0;
      end else begin
         sig_d <= sig;
         if (restart) begin
            armed   <= 1'b0;
            hi_cnt  <= '0;
            lo_cnt  <= '0;
            dec_cnt <= '0;
            stat    <= '0;
         end else if (rise) begin
            armed  <= 1'b1;
            hi_cnt <= CNT_W'(1);
            lo_cnt <= '0;
            if (armed) begin
               stat.neg <= (hi_cnt > lo_cnt);
               if (dec_cnt != SET_LIM) dec_cnt <= dec_cnt + 1'b1;
               if (dec_cnt >= SET_LIM - 1'b1) stat.valid <= 1'b1;
            end
         end else begin
            if (sig && hi_cnt != CNT_MAX)  hi_cnt <= hi_cnt + 1'b1;
            if (!sig && lo_cnt != CNT_MAX) lo_cnt <= lo_cnt + 1'b1;
         end
      end
   end

   // R8: a restart leaves the path unsettled and non-inverting
   assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!stat.valid && !stat.neg));

   // R10: the polarity flag holds between decisions
   assert_pol_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !rise) |=> $stable(stat.neg));

   // R6 / R7: settling completes only on a period boundary
   assert_valid_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat.valid) |-> $past(rise));
endmodule

// File: rtl/sync_polarity_norm.sv
module sync_polarity_norm
   import spn_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int H_SETTLE    = 4,
   parameter int V_SETTLE    = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic h_sel,
   input  logic v_sel,
   input  logic hsync_in,
   input  logic sog_in,
   input  logic vsync_in,
   input  logic vsep_in,
   output logic h_out,
   output logic v_out,
   output logic h_pol_neg,
   output logic v_pol_neg,
   output logic h_valid,
   output logic v_valid
);
   localparam int V_MIN = 5;
   localparam int N_IN  = 4;

   if (V_SETTLE < V_MIN) begin : g_bad_vsettle
      $error("sync_polarity_norm: V_SETTLE must be at least 5 frames");
   end

   logic [N_IN-1:0] raw, syn;
   logic            h_sel_q, v_sel_q, restart;
   logic            h_sig, v_sig;
   pol_stat_t       h_stat, v_stat;

   assign raw = {vsep_in, vsync_in, sog_in, hsync_in};

   spn_sync_chain #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_sel_q <= 1'b0;
         v_sel_q <= 1'b0;
      end else begin
         h_sel_q <= h_sel;
         v_sel_q <= v_sel;
      end
   end

   assign restart = (h_sel != h_sel_q) | (v_sel != v_sel_q);
   assign h_sig   = h_sel ? syn[1] : syn[0];
   assign v_sig   = v_sel ? syn[3] : syn[2];

   spn_pol_detect #(.CNT_W(CNT_W), .SETTLE(H_SETTLE)) u_hdet (
      .clk(clk), .rst_n(rst_n), .restart(restart), .sig(h_sig), .stat(h_stat)
   );

   spn_pol_detect #(.CNT_W(CNT_W), .SETTLE(V_SETTLE)) u_vdet (
      .clk(clk), .rst_n(rst_n), .restart(restart), .sig(v_sig), .stat(v_stat)
   );

   assign h_out     = h_sig ^ h_stat.neg;
   assign v_out     = v_sig ^ v_stat.neg;
   assign h_pol_neg = h_stat.neg;
   assign v_pol_neg = v_stat.neg;
   assign h_valid   = h_stat.valid;
   assign v_valid   = v_stat.valid;

   // R8: either select bit changing drops both settled flags
   assert_sel_change_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((h_sel != h_sel_q) || (v_sel != v_sel_q)) |=> (!h_valid && !v_valid));
endmodule

// File: tb/sync_polarity_norm_test.sv
module sync_polarity_norm_test;
   localparam int CLK_PERIOD = 10;
   localparam int HS = 3;
   localparam int VS = 5;
   localparam int NPER = VS + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic h_sel = 1'b0, v_sel = 1'b0;
   logic hsync_in = 1'b0, sog_in = 1'b0, vsync_in = 1'b0, vsep_in = 1'b0;
   logic h_out, v_out, h_pol_neg, v_pol_neg, h_valid, v_valid;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_polarity_norm #(.CNT_W(8), .H_SETTLE(HS), .V_SETTLE(VS), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .v_sel(v_sel),
      .hsync_in(hsync_in), .sog_in(sog_in), .vsync_in(vsync_in), .vsep_in(vsep_in),
      .h_out(h_out), .v_out(v_out), .h_pol_neg(h_pol_neg), .v_pol_neg(v_pol_neg),
      .h_valid(h_valid), .v_valid(v_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive selected sources with w, unselected with ~w; idle forces all low
   task automatic step(input bit idle, input logic w);
      @(posedge clk); #1;
      if (idle) begin
         hsync_in = 0; sog_in = 0; vsync_in = 0; vsep_in = 0;
      end else begin
         hsync_in = h_sel ? ~w : w;
         sog_in   = h_sel ? w : ~w;
         vsync_in = v_sel ? ~w : w;
         vsep_in  = v_sel ? w : ~w;
      end
      @(negedge clk);
   endtask

   task automatic run_combo(input logic ht, input logic vt, input int P, input int H, input int idx);
      int rises = 0;
      int e_hv = 0, e_vv = 0, e_ho = 0, e_vo = 0;
      logic h0 = 0, h1 = 0, h2 = 0;
      bit exp_neg = (H > P - H);
      step(1, 0);
      step(1, 0);
      // flip a single select bit for one cycle
      @(posedge clk); #1;
      if (idx % 2 == 0) h_sel = ~h_sel; else v_sel = ~v_sel;
      @(negedge clk);
      step(1, 0);
      // R8: either bit clears both paths
      chk(!h_valid && !v_valid && !h_pol_neg && !v_pol_neg, "R8 select flip clears flags",
          {h_valid, v_valid, h_pol_neg, v_pol_neg}, 0);
      @(posedge clk); #1;
      h_sel = ht; v_sel = vt;
      @(negedge clk);
      repeat (4) step(1, 0);
      for (int per = 0; per < NPER; per++) begin
         for (int c = 0; c < P; c++) begin
            logic w = (c < H);
            if (c == 0) rises++;
            step(0, w);
            h2 = h1; h1 = h0; h0 = w;
            if (c >= 4) begin
               if (h_valid !== (rises >= HS + 1)) e_hv++;
               if (v_valid !== (rises >= VS + 1)) e_vv++;
            end
            if (rises >= 3) begin
               if (h_out !== (h2 ^ exp_neg)) e_ho++;
               if (v_out !== (h2 ^ exp_neg)) e_vo++;
            end
         end
      end
      chk(e_hv == 0, "R6 h_valid settling point", e_hv, 0);
      chk(e_vv == 0, "R7 v_valid settling point", e_vv, 0);
      chk(h_pol_neg == exp_neg && h_valid, "R4 R1 horizontal polarity flag",
          {h_valid, h_pol_neg}, {1'b1, exp_neg});
      chk(v_pol_neg == exp_neg && v_valid, "R4 R2 vertical polarity flag",
          {v_valid, v_pol_neg}, {1'b1, exp_neg});
      chk(e_ho == 0, "R5 R3 h_out normalized with two-clock delay", e_ho, 0);
      chk(e_vo == 0, "R5 R3 v_out normalized with two-clock delay", e_vo, 0);
   endtask

   initial begin
      int idx = 0;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk({h_out, v_out, h_pol_neg, v_pol_neg, h_valid, v_valid} == 6'b0,
          "R9 outputs low in reset", {h_out, v_out, h_pol_neg, v_pol_neg, h_valid, v_valid}, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({h_pol_neg, v_pol_neg, h_valid, v_valid} == 4'b0,
          "R9 flags low after reset release", {h_pol_neg, v_pol_neg, h_valid, v_valid}, 0);
      for (int sel = 0; sel < 4; sel++) begin
         for (int pi = 0; pi < 2; pi++) begin
            int P = pi ? 9 : 6;
            for (int H = 1; H < P; H++) begin
               run_combo(sel[0], sel[1], P, H, idx);
               idx++;
            end
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule